// File: doc/BRIEF.md
# Shared Exclusive-Reservation Monitor

This block sits at the memory interface for shareable memory and arbitrates exclusive (load-linked / store-conditional style) accesses from several cores. It keeps one reservation slot per core. Each slot holds an Exclusive/Open flag and the block number it covers. The block number is the request address with the low `GRAN_LOG2` bits dropped, so every address inside an aligned granule maps to the same reservation.

One request per cycle arrives with a core number, an operation and a byte address. A load-exclusive arms the requester's slot. A store-exclusive is granted only against a live, matching reservation of the same core. Any write that reaches memory, whether a granted store-exclusive or an ordinary store, kills the matching reservations held by the other cores. This cross-core kill is what lets competing cores detect that they lost a race. Results come out one cycle after the request, on registered outputs: a status flag for each store-exclusive, and a write-enable with its address for the memory.

Top module: `xmon_top`

## Requirements
- R1: After reset every slot is Open, so a store-exclusive from any core fails until that core issues a load-exclusive.
- R2: `req_op` encoding: 0 = load-exclusive, 1 = store-exclusive, 2 = ordinary store, 3 = clear-exclusive. A load-exclusive sets the requester's slot to Exclusive on block `req_addr >> GRAN_LOG2`, replacing any earlier block of that slot.
- R3: A store-exclusive passes only when the requester's slot is Exclusive and its block equals the block of the store address. One cycle after the request, `rsp_valid` is 1 and `rsp_fail` is 0 on a pass or 1 on a fail. `rsp_valid` is 0 after any other operation.
- R4: `mem_we` is 1 one cycle after a passing store-exclusive or an ordinary store, with `mem_addr` equal to the request address. It is 0 after a load-exclusive, a clear-exclusive or a failing store-exclusive.
- R5: A write (passing store-exclusive or ordinary store) by one core sets to Open every other core's slot that is Exclusive on the written block. Slots on other blocks keep their state.
- R6: A failing store-exclusive writes nothing and leaves every other core's slot unchanged.
- R7: The requester's own slot becomes Open after any store-exclusive, whether it passes or fails, and after a clear-exclusive.
- R8: A load-exclusive or clear-exclusive changes no other core's slot. An ordinary store leaves the requester's own slot unchanged.
- R9: A state change caused by a request is seen by a request issued in the very next cycle.
- R10: A cycle with `req_valid` low changes no slot, and is followed by `rsp_valid` and `mem_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_core | input | CORE_W | Requesting core number |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | Store-exclusive status is valid |
| rsp_fail | output | 1 | Store-exclusive status: 0 pass, 1 fail |
| mem_we | output | 1 | Write enable to memory |
| mem_addr | output | ADDR_W | Address of the write |

## Verification
The bench goes after these corner cases:
- **Different offsets in one granule.** A design that aligned the block wrongly would fail a store-exclusive that should pass, or would skip a kill.
- **Two cores holding the same block.** A design that invalidated by exact address, or ignored the requester's own number, would let both cores succeed or would kill the writer itself.
- **Failed store-exclusive.** A design that broadcast a kill on a failed store-exclusive would clear a bystander's reservation.
- **Back-to-back requests.** Issuing the losing core's store-exclusive in the cycle right after the winning write shows whether the kill is visible at once.
- **Repeated store-exclusive and clear-exclusive.** These show whether the own slot is retired.

A long pseudo-random stream over a few addresses, compared against a bench model, covers the remaining orderings.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    OP_LDEX  = 2'd0,
    OP_STEX  = 2'd1,
    OP_STORE = 2'd2,
    OP_CLREX = 2'd3
  } xop_e;
endpackage

// File: rtl/xmon_slot.sv
// One core's reservation slot: Exclusive flag plus block number.
module xmon_slot
  import xmon_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             own_req,   // valid request from this slot's core
  input  xop_e             op,
  input  logic [TAG_W-1:0] blk,
  input  logic             kill,      // write by another core hit this block
  output logic             excl_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             excl_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      excl_q <= 1'b0;
      tag_q  <= '0;
    end else if (own_req) begin
      unique case (op)
        OP_LDEX:            begin excl_q <= 1'b1; tag_q <= blk; end
        OP_STEX, OP_CLREX:  excl_q <= 1'b0;
        default:            ;
      endcase
    end else if (kill) begin
      excl_q <= 1'b0;
    end
  end

  assign excl_o = excl_q;
  assign tag_o  = tag_q;

  a_r1_open_after_reset: assert property (@(posedge clk)
    rst |=> !excl_q);
  a_r2_ldex_arms: assert property (@(posedge clk) disable iff (rst)
    own_req && op == OP_LDEX |=> excl_q && tag_q == $past(blk));
  a_r7_own_retire: assert property (@(posedge clk) disable iff (rst)
    own_req && (op == OP_STEX || op == OP_CLREX) |=> !excl_q);
  a_r5_killed: assert property (@(posedge clk) disable iff (rst)
    kill && !own_req |=> !excl_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !own_req && !kill |=> $stable(excl_q) && $stable(tag_q));
endmodule

// File: rtl/xmon_judge.sv
// Decides pass/fail, write and cross-core kills from the current slot state.
module xmon_judge
  import xmon_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int TAG_W   = 4,
  parameter int CORE_W  = 2
) (
  input  logic                          req_valid,
  input  logic [CORE_W-1:0]             req_core,
  input  xop_e                          op,
  input  logic [TAG_W-1:0]              blk,
  input  logic [N_CORES-1:0]            excl_vec,
  input  logic [N_CORES-1:0][TAG_W-1:0] tag_vec,
  output logic                          stex,
  output logic                          pass,
  output logic                          wr,
  output logic [N_CORES-1:0]            kill_vec
);
  logic own_live;
  logic core_ok;

  assign core_ok = 32'(req_core) < N_CORES;

  always_comb begin
    own_live = 1'b0;
    for (int i = 0; i < N_CORES; i++)
      if (32'(req_core) == i) own_live = excl_vec[i] && (tag_vec[i] == blk);
  end

  assign stex = req_valid && core_ok && op == OP_STEX;
  assign pass = stex && own_live;
  assign wr   = pass || (req_valid && core_ok && op == OP_STORE);

  for (genvar g = 0; g < N_CORES; g++) begin : g_kill
    assign kill_vec[g] = wr && (32'(req_core) != g) &&
                         excl_vec[g] && (tag_vec[g] == blk);
  end
endmodule

// File: rtl/xmon_top.sv
module xmon_top
  import xmon_pkg::*;
#(
  parameter int N_CORES   = 4,
  parameter int ADDR_W    = 16,
  parameter int GRAN_LOG2 = 6,
  localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int TAG_W    = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_fail,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  xop_e                          op;
  logic [TAG_W-1:0]              blk;
  logic [N_CORES-1:0]            excl_vec;
  logic [N_CORES-1:0][TAG_W-1:0] tag_vec;
  logic [N_CORES-1:0]            kill_vec;
  logic                          stex, pass, wr;

  assign op  = xop_e'(req_op);
  assign blk = req_addr[ADDR_W-1:GRAN_LOG2];

  for (genvar g = 0; g < N_CORES; g++) begin : g_slot
    logic own_req;
    assign own_req = req_valid && (32'(req_core) == g);
    xmon_slot #(.TAG_W(TAG_W)) i_slot (
      .clk    (clk),
      .rst    (rst),
      .own_req(own_req),
      .op     (op),
      .blk    (blk),
      .kill   (kill_vec[g]),
      .excl_o (excl_vec[g]),
      .tag_o  (tag_vec[g])
    );
  end

  xmon_judge #(.N_CORES(N_CORES), .TAG_W(TAG_W), .CORE_W(CORE_W)) i_judge (
    .req_valid(req_valid),
    .req_core (req_core),
    .op       (op),
    .blk      (blk),
    .excl_vec (excl_vec),
    .tag_vec  (tag_vec),
    .stex     (stex),
    .pass     (pass),
    .wr       (wr),
    .kill_vec (kill_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= stex;
      rsp_fail  <= stex && !pass;
      mem_we    <= wr;
      if (wr) mem_addr <= req_addr;
    end
  end

  a_r6_fail_no_write: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fail |-> !mem_we);
  a_r4_pass_writes: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fail |-> mem_we);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !mem_we && !rsp_valid);
  a_r5_writer_kept: assert property (@(posedge clk) disable iff (rst)
    !($countones(kill_vec) > 0 && !wr));
  a_r8_ldex_no_kill: assert property (@(posedge clk) disable iff (rst)
    req_valid && (op == OP_LDEX || op == OP_CLREX) |-> kill_vec == '0);
endmodule

// File: tb/test_xmon_top.sv
module test_xmon_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int AW  = 8;
  localparam int G   = 4;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [CW-1:0] req_core;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic rsp_valid, rsp_fail, mem_we;
  logic [AW-1:0] mem_addr;

  int errors = 0;
  int checks = 0;
  bit m_excl [N];
  int m_tag  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xmon_top #(.N_CORES(N), .ADDR_W(AW), .GRAN_LOG2(G)) i_xmon_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_fail(rsp_fail), .mem_we(mem_we), .mem_addr(mem_addr));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one request, check the registered result, then update the model.
  task automatic req(int c, int op, int a, string tag);
    bit own_ok = m_excl[c] && (m_tag[c] == (a >> G));
    bit pass   = (op == 1) && own_ok;
    bit wr     = pass || (op == 2);
    @(negedge clk);
    req_valid = 1'b1; req_core = CW'(c); req_op = 2'(op); req_addr = AW'(a);
    @(posedge clk); #1;
    chk(tag, "rsp_valid", int'(rsp_valid), int'(op == 1));
    if (op == 1) chk(tag, "rsp_fail", int'(rsp_fail), int'(!pass));
    chk(tag, "mem_we", int'(mem_we), int'(wr));
    if (wr) chk(tag, "mem_addr", int'(mem_addr), a);
    if (wr)
      for (int k = 0; k < N; k++)
        if (k != c && m_tag[k] == (a >> G)) m_excl[k] = 1'b0;
    if (op == 0) begin m_excl[c] = 1'b1; m_tag[c] = a >> G; end
    if (op == 1 || op == 3) m_excl[c] = 1'b0;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd2; req_addr = 8'hFF;
    @(posedge clk); #1;
    chk(tag, "idle rsp_valid", int'(rsp_valid), 0);
    chk(tag, "idle mem_we", int'(mem_we), 0);
  endtask

  task automatic clear_all();
    for (int k = 0; k < N; k++) req(k, 3, 0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    rst = 1'b1; req_valid = 1'b0; req_core = '0; req_op = '0; req_addr = '0;
    for (int k = 0; k < N; k++) begin m_excl[k] = 1'b0; m_tag[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset rsp_valid", int'(rsp_valid), 0);
    chk("R1", "reset mem_we", int'(mem_we), 0);
    @(negedge clk); rst = 1'b0;

    // R1: every core fails a store-exclusive straight after reset
    for (int c = 0; c < N; c++) req(c, 1, 16 * c + 3, "R1");

    // R2 / R3: granule alignment, every offset of a block
    for (int off = 0; off < 16; off++) begin
      req(1, 0, 8'h40 + off, "R2");
      req(1, 1, 8'h40 + ((off * 7) % 16), "R3");
    end
    req(2, 0, 8'h50, "R2");
    req(2, 1, 8'h60, "R3");          // other block: fails
    req(2, 1, 8'h50, "R7");          // slot retired by the failed attempt

    // R10: idle cycles change nothing
    req(0, 0, 8'h20, "R2");
    idle("R10"); idle("R10");
    req(0, 1, 8'h2F, "R10");

    // R9 / R5: winner writes, loser tries the very next cycle
    req(0, 0, 8'h30, "R2");
    req(3, 0, 8'h34, "R2");
    req(0, 1, 8'h38, "R5");
    req(3, 1, 8'h34, "R9");

    // R6: failed store-exclusive spares a bystander
    req(1, 0, 8'h70, "R2");
    req(2, 1, 8'h70, "R6");
    req(1, 1, 8'h70, "R6");

    // R8: ordinary store keeps own slot, ldex/clrex keep others
    req(2, 0, 8'h80, "R2");
    req(2, 2, 8'h81, "R8");
    req(3, 0, 8'h80, "R8");
    req(1, 3, 8'h80, "R8");
    req(2, 1, 8'h82, "R8");

    // Sweep: two cores, same/different block, every operation of the second
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        for (int op = 0; op < 4; op++)
          for (int same = 0; same < 2; same++) begin
            if (a == b) continue;
            clear_all();
            req(a, 0, 8'h90 + a, "R2");
            req(b, 0, same ? 8'h9C : 8'hA5, "R8");
            req(b, op, same ? 8'h97 : 8'hA1, "R5");
            req(a, 1, 8'h91, "R3");
            req(b, 1, same ? 8'h9C : 8'hA5, "R7");
          end

    // Pseudo-random stream over a few blocks
    seed = 32'h1234;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      req((seed >>> 8) & 3, (seed >>> 12) & 3, (seed >>> 16) & 8'h3F, "R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule